// File: doc/BRIEF.md
# Partitioned-Address Counting Miss Filter

This block keeps a compact, conservative record of which cache lines are resident, so that a pipeline can learn early that a load will certainly miss. The line address is cut into `NUM_PARTS` disjoint fields of `FIELD_W` bits. Each field selects one counter in its own counter array, and all arrays are read in parallel. When the cache fills a line, the counter that each field of the new address selects is raised by one. When that fill also evicts a resident line, the counter that each field of the victim address selects is lowered by one in the same cycle.

A lookup is decoded combinationally from the address and registered, so the answer appears one cycle after the request. If any selected counter is zero, no resident line can share that field value, and the line is reported as a guaranteed miss. If every selected counter is nonzero, the result is "possibly hit". That answer can be wrong, because the fields of several different resident lines may together match the looked-up address. The counters are sized from the cache capacity in lines, so they cannot overflow under legal use. They also saturate at both ends.

Top module: `pamf_filter`

## Requirements
- R1: After reset every counter is zero, `result_valid` is 0, and every lookup made before the first fill reports `result_miss`=1.
- R2: Partition k is indexed by address bits [k*FIELD_W +: FIELD_W], with partition 0 in the least significant bits. An address whose field in every partition matches the field of some resident line reports `result_miss`=0, even when those fields come from different lines.
- R3: A cycle with `fill_valid`=1 raises the selected counter in every partition by one. A later lookup of the filled address reports `result_miss`=0 while the line stays resident.
- R4: A cycle with `fill_valid`=1 and `evict_valid`=1 lowers the counter that each field of `evict_addr` selects by one. Once any selected counter of an address reaches zero, that address reports `result_miss`=1.
- R5: `result_miss` is 1 exactly when at least one of the `NUM_PARTS` counters selected by the lookup address is zero. Otherwise it is 0, meaning possibly hit.
- R6: When an increment and a decrement select the same counter in the same cycle, that counter is unchanged. A fill that evicts its own address therefore leaves every counter as it was.
- R7: Counters are CNT_W = clog2(CAP_LINES+1) bits wide. An increment of a counter already at 2^CNT_W-1 leaves it there, and a decrement of a counter at zero leaves it at zero.
- R8: `evict_valid` and `evict_addr` have no effect in a cycle where `fill_valid`=0.
- R9: `result_valid` is `lookup_valid` delayed by one cycle. `result_miss` reflects the counters as they stood before any update made in the lookup cycle, and it is 0 whenever `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, empties the filter |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_addr | input | NUM_PARTS*FIELD_W | Line address to test |
| fill_valid | input | 1 | A line is being filled this cycle |
| fill_addr | input | NUM_PARTS*FIELD_W | Address of the incoming line |
| evict_valid | input | 1 | The fill displaces a resident line |
| evict_addr | input | NUM_PARTS*FIELD_W | Address of the displaced line |
| result_valid | output | 1 | Registered lookup valid |
| result_miss | output | 1 | 1 = guaranteed miss, 0 = possibly hit |

## Verification
The assertions watch every cycle. They check the one-cycle alignment of the result with its request. They check that a lookup of a line filled in the previous cycle never reports a miss. They also check how each partition's total count moves: up by one on a plain fill, unchanged on a fill with eviction or a self-swap, never down on a plain fill, and unchanged when an eviction arrives without a fill.

Some behaviours depend on long histories and on which counters are shared between lines, and only the bench scenarios can show them. These are the exact miss/possibly-hit verdict for arbitrary addresses, false positives assembled from fields of different lines, saturation at the top and at zero, and correct answers across long random fill and evict sequences.

// File: rtl/pamf_pkg.sv
package pamf_pkg;

  typedef enum logic [1:0] {
    CNT_KEEP = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;

  // Choose the counter action from the two requests that may hit an entry.
  // A simultaneous raise and lower cancel out.
  function automatic cnt_op_e pick_op(logic up_hit, logic down_hit);
    if (up_hit && down_hit) return CNT_KEEP;
    if (up_hit)             return CNT_UP;
    if (down_hit)           return CNT_DOWN;
    return CNT_KEEP;
  endfunction

  // Counter width that holds 0..lines without overflow.
  function automatic int count_width(int lines);
    return $clog2(lines + 1);
  endfunction

endpackage

// File: rtl/pamf_field_split.sv
module pamf_field_split #(
  parameter int NUM_PARTS = 4,
  parameter int FIELD_W   = 4
) (
  input  logic [NUM_PARTS*FIELD_W-1:0]     addr,
  output logic [NUM_PARTS-1:0][FIELD_W-1:0] idx
);

  localparam int ADDR_W = NUM_PARTS * FIELD_W;

  function automatic logic [FIELD_W-1:0] field_of(logic [ADDR_W-1:0] a, int part);
    return a[part*FIELD_W +: FIELD_W];
  endfunction

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    assign idx[p] = field_of(addr, p);
  end

endmodule

// File: rtl/pamf_counter_bank.sv
module pamf_counter_bank
  import pamf_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int CNT_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc_en,
  input  logic [FIELD_W-1:0]       inc_idx,
  input  logic                     dec_en,
  input  logic [FIELD_W-1:0]       dec_idx,
  input  logic [FIELD_W-1:0]       rd_idx,
  output logic                     rd_zero,
  output logic                     clip_evt,
  output logic [CNT_W+FIELD_W-1:0] pop
);

  localparam int DEPTH = 1 << FIELD_W;
  localparam int POP_W = CNT_W + FIELD_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt [DEPTH];

  function automatic logic [CNT_W-1:0] apply_op(logic [CNT_W-1:0] cur, cnt_op_e op);
    case (op)
      CNT_UP:   return (cur == CMAX) ? cur : cur + CNT_W'(1);
      CNT_DOWN: return (cur == '0)   ? cur : cur - CNT_W'(1);
      default:  return cur;
    endcase
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             up_hit;
    logic             down_hit;
    cnt_op_e          op;
    logic [CNT_W-1:0] nxt;

    assign up_hit   = inc_en && (inc_idx == FIELD_W'(e));
    assign down_hit = dec_en && (dec_idx == FIELD_W'(e));
    assign op       = pick_op(up_hit, down_hit);
    assign nxt      = apply_op(cnt[e], op);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[e] <= '0;
      else        cnt[e] <= nxt;
    end
  end

  // Named events for the checker
  logic same_entry;
  logic up_clip;
  logic down_clip;

  assign same_entry = inc_en && dec_en && (inc_idx == dec_idx);
  assign up_clip    = inc_en && !same_entry && (cnt[inc_idx] == CMAX);
  assign down_clip  = dec_en && !same_entry && (cnt[dec_idx] == '0);
  assign clip_evt   = up_clip || down_clip;

  assign rd_zero = (cnt[rd_idx] == '0);

  always_comb begin
    pop = '0;
    for (int e = 0; e < DEPTH; e++) pop = pop + POP_W'(cnt[e]);
  end

endmodule

// File: rtl/pamf_result_reg.sv
module pamf_result_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_miss,
  output logic out_valid,
  output logic out_miss
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_miss  <= in_valid && in_miss;
    end
  end

endmodule

// File: rtl/pamf_filter.sv
module pamf_filter
  import pamf_pkg::*;
#(
  parameter int NUM_PARTS = 4,
  parameter int FIELD_W   = 4,
  parameter int CAP_LINES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lookup_valid,
  input  logic [NUM_PARTS*FIELD_W-1:0] lookup_addr,
  input  logic                         fill_valid,
  input  logic [NUM_PARTS*FIELD_W-1:0] fill_addr,
  input  logic                         evict_valid,
  input  logic [NUM_PARTS*FIELD_W-1:0] evict_addr,
  output logic                         result_valid,
  output logic                         result_miss
);

  localparam int CNT_W = count_width(CAP_LINES);
  localparam int POP_W = CNT_W + FIELD_W;

  logic [NUM_PARTS-1:0][FIELD_W-1:0] look_idx;
  logic [NUM_PARTS-1:0][FIELD_W-1:0] fill_idx;
  logic [NUM_PARTS-1:0][FIELD_W-1:0] vict_idx;

  logic                            evict_take;
  logic [NUM_PARTS-1:0]            part_zero;
  logic [NUM_PARTS-1:0]            part_clip;
  logic [NUM_PARTS-1:0][POP_W-1:0] part_pop;
  logic                            lookup_miss;
  logic                            any_clip;

  pamf_field_split #(.NUM_PARTS(NUM_PARTS), .FIELD_W(FIELD_W)) u_split_look (
    .addr(lookup_addr), .idx(look_idx)
  );
  pamf_field_split #(.NUM_PARTS(NUM_PARTS), .FIELD_W(FIELD_W)) u_split_fill (
    .addr(fill_addr), .idx(fill_idx)
  );
  pamf_field_split #(.NUM_PARTS(NUM_PARTS), .FIELD_W(FIELD_W)) u_split_vict (
    .addr(evict_addr), .idx(vict_idx)
  );

  // An eviction only counts when it rides along with a fill.
  assign evict_take = fill_valid && evict_valid;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_bank
    pamf_counter_bank #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_en   (fill_valid),
      .inc_idx  (fill_idx[p]),
      .dec_en   (evict_take),
      .dec_idx  (vict_idx[p]),
      .rd_idx   (look_idx[p]),
      .rd_zero  (part_zero[p]),
      .clip_evt (part_clip[p]),
      .pop      (part_pop[p])
    );
  end

  assign lookup_miss = |part_zero;
  assign any_clip    = |part_clip;

  pamf_result_reg u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lookup_valid),
    .in_miss   (lookup_miss),
    .out_valid (result_valid),
    .out_miss  (result_miss)
  );

endmodule

// File: rtl/pamf_filter_chk.sv
module pamf_filter_chk #(
  parameter int NUM_PARTS = 4,
  parameter int FIELD_W   = 4,
  parameter int POP_W     = 11
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            lookup_valid,
  input logic [NUM_PARTS*FIELD_W-1:0]    lookup_addr,
  input logic                            fill_valid,
  input logic [NUM_PARTS*FIELD_W-1:0]    fill_addr,
  input logic                            evict_valid,
  input logic [NUM_PARTS*FIELD_W-1:0]    evict_addr,
  input logic                            result_valid,
  input logic                            result_miss,
  input logic                            any_clip,
  input logic [NUM_PARTS-1:0][POP_W-1:0] part_pop
);

  // R9: the result follows its request by exactly one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> result_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> (!result_valid && !result_miss));

  // R3: a line filled in the previous cycle, not evicted then, is never a miss
  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && $past(fill_valid) && !$past(evict_valid)
     && ($past(fill_addr) == lookup_addr)) |=> !result_miss);

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_pop
    // R3: a plain fill without clipping adds exactly one to each array total
    a_r3_pop_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !evict_valid && !any_clip)
      |=> (part_pop[p] == $past(part_pop[p]) + POP_W'(1)));
    // R4: a fill with eviction and no clipping keeps each array total
    a_r4_pop_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && evict_valid && !any_clip) |=> $stable(part_pop[p]));
    // R6: a fill that evicts its own address changes nothing
    a_r6_self_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && evict_valid && (fill_addr == evict_addr)) |=> $stable(part_pop[p]));
    // R7: a plain fill never lowers a total (no wrap at the top)
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !evict_valid) |=> (part_pop[p] >= $past(part_pop[p])));
    // R8: without a fill the counters are untouched
    a_r8_evict_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_valid |=> $stable(part_pop[p]));
  end

endmodule

bind pamf_filter pamf_filter_chk #(
  .NUM_PARTS(NUM_PARTS), .FIELD_W(FIELD_W), .POP_W(POP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lookup_valid (lookup_valid),
  .lookup_addr  (lookup_addr),
  .fill_valid   (fill_valid),
  .fill_addr    (fill_addr),
  .evict_valid  (evict_valid),
  .evict_addr   (evict_addr),
  .result_valid (result_valid),
  .result_miss  (result_miss),
  .any_clip     (any_clip),
  .part_pop     (part_pop)
);

// File: tb/pamf_filter_tb.sv
module pamf_filter_tb;

  localparam int CLK_P  = 10;
  localparam int NP     = 4;
  localparam int FW     = 4;
  localparam int CAP    = 64;
  localparam int AW     = NP * FW;
  localparam int DEPTH  = 1 << FW;
  localparam int CMAX   = (1 << $clog2(CAP + 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lookup_valid = 1'b0;
  logic [AW-1:0] lookup_addr = '0;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic          evict_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0;
  logic          result_valid;
  logic          result_miss;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int mdl [NP][DEPTH];
  logic [AW-1:0] res_list [CAP];
  int n_res = 0;

  pamf_filter #(.NUM_PARTS(NP), .FIELD_W(FW), .CAP_LINES(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .result_valid(result_valid), .result_miss(result_miss)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int fld(logic [AW-1:0] a, int p);
    return int'((a >> (p * FW)) & ((1 << FW) - 1));
  endfunction

  function automatic bit model_miss(logic [AW-1:0] a);
    for (int p = 0; p < NP; p++) if (mdl[p][fld(a, p)] == 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_update(bit fv, logic [AW-1:0] fa, bit ev, logic [AW-1:0] ea);
    if (!fv) return;
    for (int p = 0; p < NP; p++) begin
      int fi = fld(fa, p);
      int ei = fld(ea, p);
      if (ev && fi == ei) continue;
      if (mdl[p][fi] < CMAX) mdl[p][fi]++;
      if (ev && mdl[p][ei] > 0) mdl[p][ei]--;
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < NP; p++)
      for (int e = 0; e < DEPTH; e++) mdl[p][e] = 0;
    n_res = 0;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample one time unit after the rising edge.
  task automatic step(bit lv, logic [AW-1:0] la, bit fv, logic [AW-1:0] fa,
                      bit ev, logic [AW-1:0] ea, string tag);
    bit exp_miss;
    @(negedge clk);
    lookup_valid = lv; lookup_addr = la;
    fill_valid = fv;   fill_addr = fa;
    evict_valid = ev;  evict_addr = ea;
    exp_miss = lv && model_miss(la);
    model_update(fv, fa, ev, ea);
    @(posedge clk);
    #1;
    if (lv)
      chk(result_valid && (result_miss == exp_miss), tag,
          {result_valid, result_miss}, {1'b1, exp_miss});
    else
      chk(!result_valid && !result_miss, tag, {result_valid, result_miss}, 0);
  endtask

  task automatic look(logic [AW-1:0] a, string tag);
    step(1'b1, a, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lookup_valid = 1'b0; fill_valid = 1'b0; evict_valid = 1'b0;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk(!result_valid && !result_miss, "R1 reset outputs", {result_valid, result_miss}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R1: empty filter reports miss everywhere
    look(16'h0000, "R1 empty miss");
    look(16'hFFFF, "R1 empty miss");
    look(16'h1234, "R1 empty miss");

    // R9: lookup and fill of the same line in one cycle sees the old counts
    step(1'b1, 16'h1234, 1'b1, 16'h1234, 1'b0, '0, "R9 same-cycle lookup miss");
    look(16'h1234, "R3 filled line possibly hit");
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, "R9 idle no result");

    // R2: fields from two lines combine into a false positive
    step(1'b0, '0, 1'b1, 16'h5678, 1'b0, '0, "R3 fill second");
    look(16'h1278, "R2 mixed fields possibly hit");
    look(16'h5634, "R2 mixed fields possibly hit");
    look(16'h1239, "R2 field0 zero miss");
    look(16'h9234, "R2 field3 zero miss");
    look(16'h12A4, "R5 one zero field miss");

    // R8: eviction without fill is ignored
    step(1'b0, '0, 1'b0, '0, 1'b1, 16'h1234, "R8 evict alone");
    look(16'h1234, "R8 line still possibly hit");

    // R6: self-swap nets to zero
    step(1'b0, '0, 1'b1, 16'h5678, 1'b1, 16'h5678, "R6 self swap");
    look(16'h5678, "R6 line kept");

    // R4: evict 0x1234 by filling 0xABCD
    step(1'b0, '0, 1'b1, 16'hABCD, 1'b1, 16'h1234, "R4 swap");
    look(16'h1234, "R4 evicted line miss");
    look(16'hABCD, "R3 new line possibly hit");
    look(16'h5678, "R4 other line kept");

    // R7: saturation at the top and at zero
    do_reset();
    for (int i = 0; i < 200; i++)
      step(1'b0, '0, 1'b1, 16'h1111, 1'b0, '0, "R7 fill burst");
    for (int i = 0; i < CMAX - 1; i++)
      step(1'b0, '0, 1'b1, 16'h2222, 1'b1, 16'h1111, "R7 drain");
    look(16'h1111, "R7 top saturation keeps one");
    step(1'b0, '0, 1'b1, 16'h3333, 1'b1, 16'h1111, "R7 drain last");
    look(16'h1111, "R7 drained miss");
    step(1'b0, '0, 1'b1, 16'h4444, 1'b1, 16'h1111, "R7 decrement at zero");
    step(1'b0, '0, 1'b1, 16'h1111, 1'b0, '0, "R7 refill");
    look(16'h1111, "R7 zero floor then refill hit");
    step(1'b0, '0, 1'b1, 16'h5555, 1'b1, 16'h1111, "R7 evict again");
    look(16'h1111, "R7 back to miss");

    // Random legal traffic against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      bit lv, fv, ev, dup;
      logic [AW-1:0] la, fa, ea;
      int vi;
      lv = ($urandom % 4) != 0;
      if (n_res > 0 && ($urandom % 2)) la = res_list[$urandom % n_res];
      else la = AW'($urandom);
      fv = ($urandom % 3) == 0;
      ev = 1'b0; ea = AW'($urandom); fa = '0; vi = 0;
      if (fv) begin
        dup = 1'b1;
        while (dup) begin
          fa = AW'($urandom);
          dup = 1'b0;
          for (int k = 0; k < n_res; k++) if (res_list[k] == fa) dup = 1'b1;
        end
        if (n_res == CAP || (n_res > 0 && ($urandom % 3) == 0)) begin
          ev = 1'b1;
          vi = $urandom % n_res;
          ea = res_list[vi];
        end
      end else if (($urandom % 4) == 0) begin
        ev = 1'b1;
      end
      step(lv, la, fv, fa, ev, ea, "R5 random lookup");
      if (fv) begin
        if (ev) res_list[vi] = fa;
        else begin res_list[n_res] = fa; n_res++; end
      end
    end

    // R3: every resident line must report possibly hit
    for (int k = 0; k < n_res; k++) look(res_list[k], "R3 resident no false miss");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule